// File: doc/BRIEF.md
# Four-Entry Matrix Issue Scheduler

This block sits between instruction dispatch and a single execution port in an out-of-order core. It holds up to four renamed instructions. Each held instruction carries a short payload and a row of dependency bits. Bit `p` of entry `c`'s row is set while `c` still waits on the in-queue instruction in entry `p`. An entry may issue once its row is all zeros. Wakeup therefore needs no tag comparison: issuing entry `p` clears column `p` in every row at the same clock edge that frees entry `p`, so the consumers of `p` can be picked in the very next cycle.

Dispatch offers at most one instruction per cycle. It sees the lowest free slot on `alloc_idx` and is stalled by `full`. It names the producers of the new instruction by their entry index. At most one instruction leaves per cycle. Among the ready entries, the winner is chosen by a scan whose starting point comes from a free-running 4-bit LFSR, not by age. The execution side can hold issue for a cycle with `exec_busy`. A `flush` input empties the queue at once.

Top module: `iq_matrix_sched`

## Requirements
- R1: After a synchronous active-high reset, no entry is valid: `full` is 0, `alloc_idx` is 0, `issue_valid` is 0, `issue_idx` is 0 and `issue_payload` is 0.
- R2: `alloc_idx` is the lowest-numbered free entry (0 when none is free). When `disp_valid` is 1, `full` is 0 and `flush` is 0, that entry becomes valid at the next clock edge and holds `disp_payload`.
- R3: `full` is 1 exactly when all four entries are valid. While it is 1, `disp_valid` has no effect on any entry.
- R4: An entry is ready when it is valid and every bit of its dependency row is 0. Only ready entries issue.
- R5: A new entry's row is `disp_deps` (bit `p` = waits on entry `p`). The row is ANDed with the entries that are valid and not issuing in that same cycle, so bits naming free or just-issuing entries are dropped.
- R6: When `exec_busy` is 0 and some entry is ready, `issue_valid` is 1 in that same cycle and `issue_idx` names one ready entry. When `exec_busy` is 1 or nothing is ready, `issue_valid`, `issue_idx` and `issue_payload` are 0. At most one entry issues per cycle.
- R7: An entry that issues is free at the next clock edge. Its column is cleared in every row at that edge, so an entry waiting only on it is ready in the following cycle.
- R8: Pick order: a 4-bit LFSR starts at 0001 on reset. On every clock edge out of reset it becomes {s[2:0], s[3]^s[2]}. The scan starts at entry s[1:0] and steps upward modulo 4; the first ready entry wins.
- R9: When `flush` is 1, every entry is invalid after the next clock edge, and an insertion offered in that cycle is dropped.
- R10: `issue_payload` equals the payload written when the issued entry was inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_payload | input | 16 | Execution information of the offered instruction |
| disp_deps | input | 4 | Producer entries the offered instruction waits on |
| exec_busy | input | 1 | Execution port cannot accept an issue this cycle |
| full | output | 1 | All entries valid; dispatch must stall |
| alloc_idx | output | 2 | Entry the next insertion lands in |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_idx | output | 2 | Entry being issued |
| issue_payload | output | 16 | Payload of the issued entry |

## Verification
The queue cannot fill through dispatch alone. The oldest held instruction never waits on anything in the queue, so with one in and one out per cycle the occupancy stays at one. The stimulus therefore holds `exec_busy` high while building dependency chains and a full queue, then releases it and watches the drain order follow the LFSR scan. The case where a new instruction names a producer that is issuing in the same cycle is reached by inserting a consumer exactly one cycle after its producer. A reference model in the bench, built from the requirements, predicts every cycle of both a directed and a pseudo-random mix.

// File: rtl/iqm_pkg.sv
package iqm_pkg;
    localparam int IQM_DEPTH  = 4;
    localparam int IQM_PAY_W  = 16;
    localparam int IQM_LFSR_W = 4;
    localparam logic [IQM_LFSR_W-1:0] IQM_LFSR_SEED = 4'b0001;

    typedef logic [IQM_LFSR_W-1:0] iqm_lfsr_t;

    // maximal-length step for x^4 + x^3 + 1
    function automatic iqm_lfsr_t iqm_lfsr_step(input iqm_lfsr_t s);
        return {s[IQM_LFSR_W-2:0], s[IQM_LFSR_W-1] ^ s[IQM_LFSR_W-2]};
    endfunction
endpackage

// File: rtl/iqm_wakeup_matrix.sv
module iqm_wakeup_matrix #(
    parameter int DEPTH = iqm_pkg::IQM_DEPTH,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   ins_en,
    input  logic [IDX_W-1:0]       ins_idx,
    input  logic [DEPTH-1:0]       ins_deps,
    input  logic                   iss_en,
    input  logic [IDX_W-1:0]       iss_idx,
    output logic [DEPTH-1:0]       valid_o,
    output logic [DEPTH-1:0]       ready_o,
    output logic [DEPTH*DEPTH-1:0] dep_flat_o
);
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] row_q [DEPTH];
    logic [DEPTH-1:0] iss_vec;
    logic [DEPTH-1:0] live_vec;

    always_comb begin
        iss_vec = '0;
        if (iss_en) iss_vec[iss_idx] = 1'b1;
        live_vec = valid_q & ~iss_vec;
    end

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid_q[r] <= 1'b0;
                row_q[r]   <= '0;
            end else if (ins_en && (ins_idx == IDX_W'(r))) begin
                valid_q[r] <= 1'b1;
                row_q[r]   <= ins_deps & live_vec;
            end else begin
                if (iss_vec[r]) valid_q[r] <= 1'b0;
                row_q[r] <= row_q[r] & ~iss_vec;
            end
        end
        assign ready_o[r] = valid_q[r] && (row_q[r] == '0);
        assign dep_flat_o[r*DEPTH +: DEPTH] = row_q[r];
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/iqm_rand_select.sv
module iqm_rand_select #(
    parameter int DEPTH = iqm_pkg::IQM_DEPTH,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DEPTH-1:0] ready_i,
    output logic             pick_en,
    output logic [IDX_W-1:0] pick_idx
);
    import iqm_pkg::*;

    iqm_lfsr_t        lfsr_q;
    logic [IDX_W-1:0] start;
    logic [IDX_W-1:0] cand;
    logic             found;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= IQM_LFSR_SEED;
        else     lfsr_q <= iqm_lfsr_step(lfsr_q);
    end

    assign start = lfsr_q[IDX_W-1:0];

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        cand     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            cand = start + IDX_W'(k);
            if (!found && ready_i[cand]) begin
                found    = 1'b1;
                pick_idx = cand;
            end
        end
        if (hold) pick_idx = '0;
        pick_en = found && !hold;
    end
endmodule

// File: rtl/iqm_payload_ram.sv
module iqm_payload_ram #(
    parameter int DEPTH = iqm_pkg::IQM_DEPTH,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PAY_W = iqm_pkg::IQM_PAY_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [PAY_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [PAY_W-1:0] rdata
);
    logic [PAY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/iq_matrix_sched.sv
module iq_matrix_sched #(
    parameter int DEPTH = iqm_pkg::IQM_DEPTH,
    parameter int PAY_W = iqm_pkg::IQM_PAY_W,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             disp_valid,
    input  logic [PAY_W-1:0] disp_payload,
    input  logic [DEPTH-1:0] disp_deps,
    input  logic             exec_busy,
    output logic             full,
    output logic [IDX_W-1:0] alloc_idx,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_idx,
    output logic [PAY_W-1:0] issue_payload
);
    logic [DEPTH-1:0]       valid_q;
    logic [DEPTH-1:0]       ready_vec;
    logic [DEPTH*DEPTH-1:0] dep_flat;
    logic                   ins_en;
    logic                   pick_en;
    logic [IDX_W-1:0]       pick_idx;
    logic [PAY_W-1:0]       ram_rdata;
    logic                   seen_free;

    // lowest free slot
    always_comb begin
        alloc_idx = '0;
        seen_free = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!seen_free && !valid_q[i]) begin
                seen_free = 1'b1;
                alloc_idx = IDX_W'(i);
            end
        end
    end

    assign full   = &valid_q;
    assign ins_en = disp_valid && !full && !flush;

    iqm_wakeup_matrix #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_matrix (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ins_en    (ins_en),
        .ins_idx   (alloc_idx),
        .ins_deps  (disp_deps),
        .iss_en    (pick_en),
        .iss_idx   (pick_idx),
        .valid_o   (valid_q),
        .ready_o   (ready_vec),
        .dep_flat_o(dep_flat)
    );

    iqm_rand_select #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_select (
        .clk     (clk),
        .rst     (rst),
        .hold    (exec_busy),
        .ready_i (ready_vec),
        .pick_en (pick_en),
        .pick_idx(pick_idx)
    );

    iqm_payload_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAY_W(PAY_W)) u_payload (
        .clk  (clk),
        .we   (ins_en),
        .waddr(alloc_idx),
        .wdata(disp_payload),
        .raddr(pick_idx),
        .rdata(ram_rdata)
    );

    assign issue_valid   = pick_en;
    assign issue_idx     = pick_idx;
    assign issue_payload = pick_en ? ram_rdata : '0;
endmodule

// File: rtl/iqm_sched_checker.sv
module iqm_sched_checker #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   flush,
    input logic                   disp_valid,
    input logic                   exec_busy,
    input logic                   full,
    input logic [IDX_W-1:0]       alloc_idx,
    input logic                   issue_valid,
    input logic [IDX_W-1:0]       issue_idx,
    input logic [DEPTH-1:0]       valid_q,
    input logic [DEPTH*DEPTH-1:0] dep_flat
);
    logic [DEPTH-1:0] col_any;
    logic [DEPTH-1:0] row_clear;
    logic [DEPTH-1:0] diag;

    always_comb begin
        col_any   = '0;
        row_clear = '1;
        for (int r = 0; r < DEPTH; r++) begin
            diag[r] = dep_flat[r*DEPTH + r];
            for (int c = 0; c < DEPTH; c++) begin
                if (dep_flat[r*DEPTH + c]) begin
                    col_any[c]   = 1'b1;
                    row_clear[r] = 1'b0;
                end
            end
        end
    end

    // R2
    a_r2_insert_lands: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !full && !flush |=> valid_q[$past(alloc_idx)]);

    // R3
    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        full && !issue_valid && !flush |=> full);

    // R4
    a_r4_pick_is_ready: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> valid_q[issue_idx] && row_clear[issue_idx]);

    // R5
    a_r5_no_self_wait: assert property (@(posedge clk) disable iff (rst)
        (diag & valid_q) == '0);

    // R6
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        exec_busy |-> !issue_valid);

    // R7
    a_r7_slot_freed: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !valid_q[$past(issue_idx)]);

    // R7
    a_r7_column_cleared: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !col_any[$past(issue_idx)]);

    // R9
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> valid_q == '0);
endmodule

bind iq_matrix_sched iqm_sched_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .disp_valid (disp_valid),
    .exec_busy  (exec_busy),
    .full       (full),
    .alloc_idx  (alloc_idx),
    .issue_valid(issue_valid),
    .issue_idx  (issue_idx),
    .valid_q    (valid_q),
    .dep_flat   (dep_flat)
);

// File: tb/sim_iq_matrix_sched.sv
`timescale 1ns/1ps
module sim_iq_matrix_sched;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic [15:0] disp_payload = '0;
    logic [3:0]  disp_deps = '0;
    logic        exec_busy = 1'b0;
    logic        full;
    logic [1:0]  alloc_idx;
    logic        issue_valid;
    logic [1:0]  issue_idx;
    logic [15:0] issue_payload;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0]  m_valid;
    logic [3:0]  m_row [4];
    logic [15:0] m_pay [4];
    logic [3:0]  m_lfsr;

    always #5 clk = ~clk;

    iq_matrix_sched u0 (
        .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
        .disp_payload(disp_payload), .disp_deps(disp_deps), .exec_busy(exec_busy),
        .full(full), .alloc_idx(alloc_idx), .issue_valid(issue_valid),
        .issue_idx(issue_idx), .issue_payload(issue_payload)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] m_free();
        for (int i = 0; i < 4; i++) if (!m_valid[i]) return 2'(i);
        return 2'd0;
    endfunction

    // one cycle: drive, compare outputs against the model, clock, update model
    task automatic step(input bit dv, input logic [15:0] pl, input logic [3:0] dp,
                        input bit busy, input bit fl, input string tag);
        logic [3:0] rdy;
        logic [3:0] ivec;
        logic [3:0] live;
        bit         e_iv;
        logic [1:0] e_idx;
        logic [1:0] slot;
        bit         e_full;
        disp_valid = dv; disp_payload = pl; disp_deps = dp; exec_busy = busy; flush = fl;
        #1;
        for (int i = 0; i < 4; i++) rdy[i] = m_valid[i] && (m_row[i] == 4'd0);
        e_iv = 1'b0; e_idx = 2'd0;
        if (!busy) begin
            for (int k = 0; k < 4; k++) begin
                logic [1:0] c;
                c = m_lfsr[1:0] + 2'(k);
                if (!e_iv && rdy[c]) begin e_iv = 1'b1; e_idx = c; end
            end
        end
        e_full = (m_valid == 4'hF);
        slot = m_free();
        chk(tag, "full", int'(full), int'(e_full));
        chk(tag, "alloc_idx", int'(alloc_idx), int'(slot));
        chk(tag, "issue_valid", int'(issue_valid), int'(e_iv));
        chk(tag, "issue_idx", int'(issue_idx), int'(e_idx));
        chk(tag, "issue_payload", int'(issue_payload), e_iv ? int'(m_pay[e_idx]) : 0);
        @(posedge clk);
        ivec = 4'd0;
        if (e_iv) ivec[e_idx] = 1'b1;
        live = m_valid & ~ivec;
        if (fl) begin
            m_valid = 4'd0;
            for (int i = 0; i < 4; i++) m_row[i] = 4'd0;
        end else begin
            m_valid = m_valid & ~ivec;
            for (int i = 0; i < 4; i++) m_row[i] = m_row[i] & ~ivec;
            if (dv && !e_full) begin
                m_valid[slot] = 1'b1;
                m_row[slot]   = dp & live;
                m_pay[slot]   = pl;
            end
        end
        m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
        @(negedge clk);
    endtask

    task automatic drain(input string tag);
        for (int n = 0; n < 12 && m_valid != 4'd0; n++) step(0, 16'h0, 4'h0, 0, 0, tag);
        chk(tag, "drained", int'(m_valid == 4'd0), 1);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_valid = 4'd0; m_lfsr = 4'b0001;
        for (int i = 0; i < 4; i++) begin m_row[i] = 4'd0; m_pay[i] = 16'd0; end
        #1;
        chk("R1", "full", int'(full), 0);
        chk("R1", "alloc_idx", int'(alloc_idx), 0);
        chk("R1", "issue_valid", int'(issue_valid), 0);
        chk("R1", "issue_idx", int'(issue_idx), 0);
        chk("R1", "issue_payload", int'(issue_payload), 0);
    endtask

    // R2 R6 R10: lone independent instruction issues the cycle after insertion
    task automatic t_single();
        step(1, 16'hA001, 4'h0, 0, 0, "R2");
        chk("R6", "lone ready issues", int'(issue_valid), 1);
        chk("R10", "lone payload", int'(issue_payload), 16'hA001);
        step(0, 16'h0, 4'h0, 0, 0, "R10");
        drain("R7");
    endtask

    // R3: fill while execution is busy, fifth offer ignored
    task automatic t_full();
        for (int n = 0; n < 5; n++) step(1, 16'hB000 + 16'(n), 4'h0, 1, 0, "R3");
        chk("R3", "full after fill", int'(full), 1);
        step(1, 16'hBEEF, 4'h0, 1, 0, "R3");
        drain("R8");
    endtask

    // R4 R7: chain A<-B<-C, D<-A built under busy, drained in dependency order
    task automatic t_chain();
        step(1, 16'hC000, 4'b0000, 1, 0, "R4");
        step(1, 16'hC001, 4'b0001, 1, 0, "R4");
        step(1, 16'hC002, 4'b0010, 1, 0, "R4");
        step(1, 16'hC003, 4'b0001, 1, 0, "R4");
        chk("R4", "only A ready: issue_idx", int'(issue_idx), 0);
        step(0, 16'h0, 4'h0, 0, 0, "R7");
        drain("R7");
    endtask

    // R5: consumer names a producer issuing in the same cycle, and stale entries
    task automatic t_mask();
        step(1, 16'hD000, 4'b0000, 0, 0, "R5");
        step(1, 16'hD001, 4'b0001, 0, 0, "R5");
        chk("R5", "masked consumer issues next", int'(issue_valid), 1);
        chk("R5", "masked consumer payload", int'(issue_payload), 16'hD001);
        step(0, 16'h0, 4'h0, 0, 0, "R5");
        step(1, 16'hD002, 4'b1110, 0, 0, "R5");
        chk("R5", "stale deps dropped", int'(issue_payload), 16'hD002);
        drain("R5");
    endtask

    // R9: flush drops contents and a simultaneous insertion
    task automatic t_flush();
        for (int n = 0; n < 3; n++) step(1, 16'hE000 + 16'(n), 4'h0, 1, 0, "R9");
        step(1, 16'hE0FF, 4'h0, 1, 1, "R9");
        chk("R9", "empty after flush", int'(alloc_idx), 0);
        chk("R9", "no issue after flush", int'(issue_valid), 0);
        step(0, 16'h0, 4'h0, 0, 0, "R9");
    endtask

    // R8 R6: pseudo-random mix
    task automatic t_mix();
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], 16'(r[31:16]), r[5:2], r[6] & r[7], (r[15:8] == 8'h00), "R8");
        end
        drain("R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_full();
        t_chain();
        t_mask();
        t_flush();
        t_mix();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule